// File: doc/BRIEF.md
# Four-Bit Bidirectional Shift Register with Parallel Load

The block is a small storage register that shifts and loads. On every rising clock edge it holds its contents, shifts one place toward the right, shifts one place toward the left, or takes a whole new word from its parallel input. A two-bit operation code selects which of these happens. Bit 3 is the leftmost position and bit 0 is the rightmost. Each end has its own serial input, so one register can shift data in from either side. Both end bits are also brought out as serial outputs.

A synchronous clear input forces the register to zero whatever the operation code says. A synchronous active-high reset does the same thing. The design can be used as a serial-to-parallel converter, a parallel-to-serial converter, or a stage in a longer shift chain that is built by joining end outputs to the neighbour's serial inputs.

Top module: `ush_reg`

## Requirements
- R1: When `rst` is high at a rising edge, `par_out` reads 4'b0000 after that edge.
- R2: When `op` is 2'b00 (hold) and `clr` is low, `par_out` keeps its value across the edge.
- R3: When `op` is 2'b01 (shift right) and `clr` is low, each bit i < 3 takes the old bit i+1, and bit 3 takes `ser_from_left`.
- R4: When `op` is 2'b10 (shift left) and `clr` is low, each bit i > 0 takes the old bit i-1, and bit 0 takes `ser_from_right`.
- R5: When `op` is 2'b11 (load) and `clr` is low, all four bits take `par_in` on the same edge.
- R6: When `clr` is high at a rising edge, `par_out` reads 4'b0000 after that edge for every value of `op`.
- R7: `left_out` always equals bit 3 of `par_out`, and `right_out` always equals bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear; overrides `op` |
| op | input | 2 | Operation: 00 hold, 01 shift right, 10 shift left, 11 load |
| ser_from_left | input | 1 | Serial bit entering bit 3 on a right shift |
| ser_from_right | input | 1 | Serial bit entering bit 0 on a left shift |
| par_in | input | 4 | Parallel load word |
| par_out | output | 4 | Stored word |
| left_out | output | 1 | Leftmost stored bit (bit 3) |
| right_out | output | 1 | Rightmost stored bit (bit 0) |

## Verification
The hardest case to reach is clear arriving together with a shift or a load whose result would be non-zero. That case shows whether clear really takes priority. To set it up, the stimulus first loads a non-zero word, then raises `clr` once under each of the four operation codes. Each time it sets the serial and parallel inputs to ones, so that a missing priority would leave ones in the register. A long stretch of random codes follows. It also walks serial patterns in from both ends, so each end bit is seen entering, travelling and leaving.

// File: rtl/ush_pkg.sv
package ush_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_SHR  = 2'b01,
        OP_SHL  = 2'b10,
        OP_LOAD = 2'b11
    } op_e;

    // Per-bit source choice: itself, neighbour on the left, neighbour on the right, load bit
    function automatic logic pick_next(input op_e o, input logic self_b,
                                       input logic left_b, input logic right_b,
                                       input logic load_b);
        logic r;
        case (o)
            OP_HOLD: r = self_b;
            OP_SHR:  r = left_b;
            OP_SHL:  r = right_b;
            default: r = load_b;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/ush_cell.sv
module ush_cell
    import ush_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  op_e  op,
    input  logic from_left,
    input  logic from_right,
    input  logic load_bit,
    output logic q
);
    logic d;

    always_comb begin
        if (clr) d = 1'b0;
        else     d = pick_next(op, q, from_left, from_right, load_bit);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= d;
    end
endmodule

// File: rtl/ush_bank.sv
module ush_bank
    import ush_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  op_e              op,
    input  logic             ser_l,
    input  logic             ser_r,
    input  logic [WIDTH-1:0] load_word,
    output logic [WIDTH-1:0] q
);
    localparam int TOP = WIDTH - 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic lft, rgt;
        if (i == TOP) begin : g_lend
            assign lft = ser_l;
        end else begin : g_lmid
            assign lft = q[i+1];
        end
        if (i == 0) begin : g_rend
            assign rgt = ser_r;
        end else begin : g_rmid
            assign rgt = q[i-1];
        end
        ush_cell u_cell (
            .clk       (clk),
            .rst       (rst),
            .clr       (clr),
            .op        (op),
            .from_left (lft),
            .from_right(rgt),
            .load_bit  (load_word[i]),
            .q         (q[i])
        );
    end
endmodule

// File: rtl/ush_reg.sv
module ush_reg
    import ush_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [1:0]       op,
    input  logic             ser_from_left,
    input  logic             ser_from_right,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] par_out,
    output logic             left_out,
    output logic             right_out
);
    localparam int TOP = WIDTH - 1;

    op_e              op_q;
    logic [WIDTH-1:0] store;

    assign op_q = op_e'(op);

    ush_bank #(.WIDTH(WIDTH)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .op       (op_q),
        .ser_l    (ser_from_left),
        .ser_r    (ser_from_right),
        .load_word(par_in),
        .q        (store)
    );

    assign par_out   = store;
    assign left_out  = store[TOP];
    assign right_out = store[0];
endmodule

// File: rtl/ush_reg_chk.sv
module ush_reg_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic [1:0]       op,
    input logic             ser_from_left,
    input logic             ser_from_right,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] par_out,
    input logic             left_out,
    input logic             right_out
);
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (par_out == '0));

    p_hold_keeps_r2: assert property (@(posedge clk) disable iff (rst)
        (!clr && op == 2'b00) |=> (par_out == $past(par_out)));

    p_shift_right_r3: assert property (@(posedge clk) disable iff (rst)
        (!clr && op == 2'b01) |=>
            (par_out == {$past(ser_from_left), $past(par_out[WIDTH-1:1])}));

    p_shift_left_r4: assert property (@(posedge clk) disable iff (rst)
        (!clr && op == 2'b10) |=>
            (par_out == {$past(par_out[WIDTH-2:0]), $past(ser_from_right)}));

    p_load_word_r5: assert property (@(posedge clk) disable iff (rst)
        (!clr && op == 2'b11) |=> (par_out == $past(par_in)));

    p_clear_wins_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (par_out == '0));

    p_end_bits_r7: assert property (@(posedge clk) disable iff (rst)
        (left_out == par_out[WIDTH-1]) && (right_out == par_out[0]));
endmodule

bind ush_reg ush_reg_chk #(.WIDTH(WIDTH)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .clr           (clr),
    .op            (op),
    .ser_from_left (ser_from_left),
    .ser_from_right(ser_from_right),
    .par_in        (par_in),
    .par_out       (par_out),
    .left_out      (left_out),
    .right_out     (right_out)
);

// File: tb/ush_reg_tb.sv
`timescale 1ns/1ps
module ush_reg_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr = 1'b0;
    logic [1:0] op = 2'b00;
    logic       sl = 1'b0;
    logic       sr = 1'b0;
    logic [3:0] pin = 4'h0;
    logic [3:0] pout;
    logic       lo, ro;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [3:0] v;
        string      tag;
    } exp_t;
    exp_t sbq[$];
    logic [3:0] model = 4'h0;

    always #2 clk = ~clk;

    ush_reg dut_i (
        .clk(clk), .rst(rst), .clr(clr), .op(op),
        .ser_from_left(sl), .ser_from_right(sr),
        .par_in(pin), .par_out(pout), .left_out(lo), .right_out(ro)
    );

    // Driver: set inputs after a falling edge, predict the word and queue it
    task automatic drive(input logic r, input logic c, input logic [1:0] o,
                         input logic l, input logic rr, input logic [3:0] p);
        exp_t e;
        @(negedge clk);
        rst = r; clr = c; op = o; sl = l; sr = rr; pin = p;
        if (r)                 begin model = 4'h0;                e.tag = "R1"; end
        else if (c)            begin model = 4'h0;                e.tag = "R6"; end
        else if (o == 2'b00)   begin                              e.tag = "R2"; end
        else if (o == 2'b01)   begin model = {l, model[3:1]};     e.tag = "R3"; end
        else if (o == 2'b10)   begin model = {model[2:0], rr};    e.tag = "R4"; end
        else                   begin model = p;                   e.tag = "R5"; end
        e.v = model;
        sbq.push_back(e);
    endtask

    // Monitor: one queued item per edge, compared 1 ns after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                checks++;
                if (pout !== e.v) begin
                    fails++;
                    $display("FAIL %s: par_out=%b expected %b", e.tag, pout, e.v);
                end
                checks++;
                if (lo !== e.v[3] || ro !== e.v[0]) begin
                    fails++;
                    $display("FAIL R7: left_out/right_out=%b%b expected %b%b",
                             lo, ro, e.v[3], e.v[0]);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        drive(1, 0, 2'b11, 1, 1, 4'hF);       // R1: reset beats load
        drive(1, 0, 2'b00, 0, 0, 4'h0);
        drive(0, 0, 2'b11, 0, 0, 4'b1011);    // R5
        drive(0, 0, 2'b00, 1, 1, 4'h0);       // R2
        drive(0, 0, 2'b00, 0, 0, 4'hF);
        drive(0, 0, 2'b01, 0, 1, 4'h0);       // R3: walk a pattern in from the left
        drive(0, 0, 2'b01, 1, 0, 4'h0);
        drive(0, 0, 2'b01, 1, 0, 4'h0);
        drive(0, 0, 2'b01, 0, 1, 4'h0);
        drive(0, 0, 2'b01, 1, 0, 4'h0);
        drive(0, 0, 2'b10, 0, 1, 4'h0);       // R4: walk a pattern in from the right
        drive(0, 0, 2'b10, 1, 0, 4'h0);
        drive(0, 0, 2'b10, 0, 1, 4'h0);
        drive(0, 0, 2'b10, 0, 0, 4'h0);
        drive(0, 0, 2'b10, 1, 1, 4'h0);
        // R6: clear under every operation code, with ones offered everywhere
        for (int k = 0; k < 4; k++) begin
            drive(0, 0, 2'b11, 1, 1, 4'b0110);
            drive(0, 1, k[1:0], 1, 1, 4'hF);
        end
        drive(0, 0, 2'b11, 0, 0, 4'b1001);
        drive(1, 0, 2'b01, 1, 1, 4'h0);       // R1 mid-run
        for (int k = 0; k < 400; k++) begin
            logic [7:0] rv;
            rv = 8'($urandom);
            drive(rv[7:5] == 3'b000, rv[4:2] == 3'b000, rv[1:0],
                  1'($urandom), 1'($urandom), 4'($urandom));
        end
        @(posedge clk);
        #2;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule